// File: doc/BRIEF.md
# Two-Phase Voltage Sag Detector

This block watches the voltage sample stream of each phase of a polyphase supply. A sample counts as low when its magnitude falls below a programmable threshold. A phase is declared to be in sag once it produces an unbroken run of low samples whose length reaches a programmable count. Each phase has its own status flag. Any sample at or above the threshold ends the run and drops the flag of that phase.

A per-phase enable mask picks the phases that feed one combined interrupt. When several phases are picked, the interrupt fires only while every picked phase is in sag at the same time. A separate enable bit gates the combined indication onto the external pin. The threshold, the run length, the masks and the pin enable arrive as plain inputs from registers outside the block. Suggested reset settings for those registers are a threshold of 443000 and a run length of 80. These settings are provided as package constants.

Top module: `sag_detector`

## Requirements
- R1: A valid sample is low when the absolute value of its two's-complement data is strictly less than `sagThreshold`. A sample equal to the threshold is not low. Negative and positive samples of equal magnitude behave the same.
- R2: A phase's `sagFlag` bit goes high in the cycle after the valid strobe that carries the N-th consecutive low sample of that phase, where N is `sagCount`. It stays low after N-1 such samples.
- R3: A valid sample of a phase that is not low clears that phase's run counter and drops its `sagFlag` bit in the next cycle.
- R4: The run counter saturates at N and does not wrap. The flag stays high for as long as further low samples keep arriving, including past 255 samples.
- R5: A `sagCount` value of 0 acts as 1, so a single low sample raises the flag.
- R6: A phase's counter and flag change only on cycles when its bit of `sampleValid` is high. Each phase is independent of the other.
- R7: `sagMask` bit 0 selects phase A and bit 1 selects phase B. The combined indication is high only while every selected phase's flag is high (logical AND).
- R8: With `sagMask` equal to 0, `sagIrq` stays low while the per-phase flags keep updating.
- R9: `sagIrq` is low whenever `sagIrqEn` is 0. Otherwise it follows the combined indication in the same cycle.
- R10: A synchronous active-high `rst` clears all counters and flags, and so `sagIrq` as well.
- R11: The maximum run length of 255 is honoured. The flag rises on the 255th low sample and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | PHASES | Per-phase sample strobe; bit 0 is phase A |
| sampleData | input | PHASES*SAMPLE_W | Signed samples; phase A in the low slice |
| sagThreshold | input | SAMPLE_W | Unsigned magnitude threshold |
| sagCount | input | CNT_W | Required run of low samples (0 acts as 1) |
| sagMask | input | PHASES | Phases that take part in the combined interrupt |
| sagIrqEn | input | 1 | Gates the combined indication onto `sagIrq` |
| sagFlag | output | PHASES | Per-phase sag status |
| sagIrq | output | 1 | Combined sag interrupt for the pin |

## Verification
The hardest state to reach is the long-run boundary. The flag must still be low after 254 consecutive low samples and must rise on the 255th, with no stray high sample anywhere in the run. A directed sequence builds that run sample by sample, then pushes it past the saturation point. The AND combination needs both phases in sag at once, so directed steps bring phase A into sag first and then complete phase B's run. Constrained random traffic runs with short run lengths and thresholds close to the sample range. This mixes partial runs, idle strobes, run-length changes in mid-run and mask changes, and a bench model predicts the outcome.

// File: rtl/sag_pkg.sv
package sag_pkg;
  // Per-phase command from control to datapath for one valid sample.
  typedef struct packed {
    logic clr;  // valid sample at or above threshold: restart run
    logic adv;  // valid low sample: extend run
  } phase_strobe_t;

  // Suggested settings for the registers that feed the block.
  localparam int DEF_THRESHOLD = 443000;
  localparam int DEF_RUN_COUNT = 80;
endpackage

// File: rtl/sag_datapath.sv
module sag_datapath
  import sag_pkg::*;
#(
  parameter int PHASES   = 2,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [PHASES*SAMPLE_W-1:0]   sampleData,
  input  logic [SAMPLE_W-1:0]          sagThreshold,
  input  logic [CNT_W-1:0]             sagCount,
  input  phase_strobe_t [PHASES-1:0]   strobe,
  output logic [PHASES-1:0]            belowThr,
  output logic [PHASES-1:0]            runReached
);
  localparam logic [SAMPLE_W-1:0] ONE_S = SAMPLE_W'(1);
  localparam logic [CNT_W-1:0]    ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] target;
  assign target = (sagCount == '0) ? ONE_C : sagCount;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] magnitude;
    logic [CNT_W-1:0]    runCnt;

    assign raw       = sampleData[p*SAMPLE_W +: SAMPLE_W];
    assign magnitude = raw[SAMPLE_W-1] ? (~raw + ONE_S) : raw;
    assign belowThr[p]   = magnitude < sagThreshold;
    assign runReached[p] = (runCnt >= target) || ((runCnt + ONE_C) == target);

    always_ff @(posedge clk) begin
      if (rst) begin
        runCnt <= '0;
      end else if (strobe[p].clr) begin
        runCnt <= '0;
      end else if (strobe[p].adv) begin
        runCnt <= runReached[p] ? target : runCnt + ONE_C;
      end
    end
  end
endmodule

// File: rtl/sag_control.sv
module sag_control
  import sag_pkg::*;
#(
  parameter int PHASES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASES-1:0]          sampleValid,
  input  logic [PHASES-1:0]          belowThr,
  input  logic [PHASES-1:0]          runReached,
  input  logic [PHASES-1:0]          sagMask,
  input  logic                       sagIrqEn,
  output phase_strobe_t [PHASES-1:0] strobe,
  output logic [PHASES-1:0]          sagFlag,
  output logic                       sagIrq
);
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign strobe[p].clr = sampleValid[p] & ~belowThr[p];
    assign strobe[p].adv = sampleValid[p] &  belowThr[p];

    always_ff @(posedge clk) begin
      if (rst) begin
        sagFlag[p] <= 1'b0;
      end else if (strobe[p].clr) begin
        sagFlag[p] <= 1'b0;
      end else if (strobe[p].adv) begin
        sagFlag[p] <= runReached[p];
      end
    end
  end

  logic allSelectedInSag;
  assign allSelectedInSag = (|sagMask) && (&(sagFlag | ~sagMask));
  assign sagIrq = sagIrqEn & allSelectedInSag;
endmodule

// File: rtl/sag_detector.sv
module sag_detector
  import sag_pkg::*;
#(
  parameter int PHASES   = 2,
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PHASES-1:0]          sampleValid,
  input  logic [PHASES*SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0]        sagThreshold,
  input  logic [CNT_W-1:0]           sagCount,
  input  logic [PHASES-1:0]          sagMask,
  input  logic                       sagIrqEn,
  output logic [PHASES-1:0]          sagFlag,
  output logic                       sagIrq
);
  phase_strobe_t [PHASES-1:0] strobe;
  logic [PHASES-1:0] belowThr;
  logic [PHASES-1:0] runReached;

  sag_datapath #(.PHASES(PHASES), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .sampleData   (sampleData),
    .sagThreshold (sagThreshold),
    .sagCount     (sagCount),
    .strobe       (strobe),
    .belowThr     (belowThr),
    .runReached   (runReached)
  );

  sag_control #(.PHASES(PHASES)) u_control (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .belowThr    (belowThr),
    .runReached  (runReached),
    .sagMask     (sagMask),
    .sagIrqEn    (sagIrqEn),
    .strobe      (strobe),
    .sagFlag     (sagFlag),
    .sagIrq      (sagIrq)
  );
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int PHASES   = 2,
  parameter int SAMPLE_W = 24
) (
  input logic                       clk,
  input logic                       rst,
  input logic [PHASES-1:0]          sampleValid,
  input logic [PHASES*SAMPLE_W-1:0] sampleData,
  input logic [SAMPLE_W-1:0]        sagThreshold,
  input logic [PHASES-1:0]          sagMask,
  input logic                       sagIrqEn,
  input logic [PHASES-1:0]          sagFlag,
  input logic                       sagIrq
);
  for (genvar p = 0; p < PHASES; p++) begin : g_chk
    logic signed [SAMPLE_W:0] wide;
    logic [SAMPLE_W:0]        absVal;
    logic                     isHigh;
    assign wide   = {sampleData[p*SAMPLE_W+SAMPLE_W-1], sampleData[p*SAMPLE_W +: SAMPLE_W]};
    assign absVal = (wide < 0) ? -wide : wide;
    assign isHigh = absVal >= {1'b0, sagThreshold};

    // R3
    clear_on_high_chk: assert property (@(posedge clk) disable iff (rst)
      (sampleValid[p] && isHigh) |=> !sagFlag[p]);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !sampleValid[p] |=> $stable(sagFlag[p]));

    // R6
    rise_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sagFlag[p]) |-> $past(sampleValid[p]));

    // R7
    irq_needs_phase_chk: assert property (@(posedge clk) disable iff (rst)
      (sagIrq && sagMask[p]) |-> sagFlag[p]);
  end

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !sagIrqEn |-> !sagIrq);

  // R8
  irq_nomask_chk: assert property (@(posedge clk) disable iff (rst)
    (sagMask == '0) |-> !sagIrq);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (sagFlag == '0));
endmodule

bind sag_detector sag_checker #(.PHASES(PHASES), .SAMPLE_W(SAMPLE_W)) u_sag_checker (
  .clk          (clk),
  .rst          (rst),
  .sampleValid  (sampleValid),
  .sampleData   (sampleData),
  .sagThreshold (sagThreshold),
  .sagMask      (sagMask),
  .sagIrqEn     (sagIrqEn),
  .sagFlag      (sagFlag),
  .sagIrq       (sagIrq)
);

// File: tb/test_sag_detector.sv
module test_sag_detector;
  localparam int CLK_PERIOD = 10;
  localparam int PHASES   = 2;
  localparam int SAMPLE_W = 24;
  localparam int CNT_W    = 8;

  logic clk = 1'b0;
  logic rst;
  logic [PHASES-1:0] sampleValid;
  logic signed [SAMPLE_W-1:0] sd [PHASES];
  logic [PHASES*SAMPLE_W-1:0] sampleData;
  logic [SAMPLE_W-1:0] sagThreshold;
  logic [CNT_W-1:0] sagCount;
  logic [PHASES-1:0] sagMask;
  logic sagIrqEn;
  logic [PHASES-1:0] sagFlag;
  logic sagIrq;

  assign sampleData = {sd[1], sd[0]};

  always #(CLK_PERIOD/2) clk = ~clk;

  sag_detector #(.PHASES(PHASES), .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_sag_detector (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .sampleData(sampleData),
    .sagThreshold(sagThreshold), .sagCount(sagCount), .sagMask(sagMask),
    .sagIrqEn(sagIrqEn), .sagFlag(sagFlag), .sagIrq(sagIrq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int mCnt [PHASES];
  bit mFlag [PHASES];

  function automatic bit isLow(int v, int thr);
    int mag = (v < 0) ? -v : v;
    return mag < thr;
  endfunction

  function automatic int targetOf(int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  function automatic bit expIrq();
    bit all = 1;
    if (!sagIrqEn || sagMask == '0) return 0;
    for (int p = 0; p < PHASES; p++) if (sagMask[p] && !mFlag[p]) all = 0;
    return all;
  endfunction

  task automatic modelStep();
    for (int p = 0; p < PHASES; p++) begin
      if (rst) begin
        mCnt[p] = 0; mFlag[p] = 0;
      end else if (sampleValid[p]) begin
        if (isLow(int'(sd[p]), int'(sagThreshold))) begin
          int t = targetOf(int'(sagCount));
          mCnt[p]  = (mCnt[p] >= t) ? t : mCnt[p] + 1;
          mFlag[p] = (mCnt[p] >= t);
        end else begin
          mCnt[p] = 0; mFlag[p] = 0;
        end
      end
    end
  endtask

  task automatic check(string tag, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // One clock: inputs already set at negedge; compare at the next negedge.
  task automatic cycle(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    for (int p = 0; p < PHASES; p++) check(tag, int'(sagFlag[p]), int'(mFlag[p]));
    check(tag, int'(sagIrq), int'(expIrq()));
  endtask

  task automatic drive(bit [1:0] v, int a, int b);
    sampleValid = v; sd[0] = SAMPLE_W'(a); sd[1] = SAMPLE_W'(b);
  endtask

  task automatic doReset();
    rst = 1; sampleValid = '0; cycle("R10"); rst = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int p = 0; p < PHASES; p++) begin mCnt[p] = 0; mFlag[p] = 0; end
    rst = 1; sampleValid = '0; sd[0] = '0; sd[1] = '0;
    sagThreshold = 24'd1000; sagCount = 8'd4; sagMask = 2'b01; sagIrqEn = 1'b1;
    @(negedge clk);
    doReset();
    check("R10", int'(sagFlag), 0);
    check("R10", int'(sagIrq), 0);

    // R2 / R1: three low samples (mixed sign) are not enough, the fourth raises the flag
    drive(2'b01, 999, 0);  cycle("R2");
    drive(2'b01, -999, 0); cycle("R1");
    drive(2'b01, 5, 0);    cycle("R2");
    check("R2", int'(sagFlag[0]), 0);
    drive(2'b01, -1, 0);   cycle("R2");
    check("R2", int'(sagFlag[0]), 1);
    check("R7", int'(sagIrq), 1);
    // R1 / R3: sample equal to the threshold clears
    drive(2'b01, -1000, 0); cycle("R3");
    check("R3", int'(sagFlag[0]), 0);
    check("R1", int'(sagIrq), 0);

    // R11 / R4: run of 255
    sagCount = 8'd255;
    for (int i = 0; i < 254; i++) begin drive(2'b01, 10, 0); cycle("R11"); end
    check("R11", int'(sagFlag[0]), 0);
    drive(2'b01, 10, 0); cycle("R11");
    check("R11", int'(sagFlag[0]), 1);
    for (int i = 0; i < 20; i++) begin drive(2'b01, -10, 0); cycle("R4"); end
    check("R4", int'(sagFlag[0]), 1);

    // R6: idle strobes with high data change nothing
    for (int i = 0; i < 5; i++) begin drive(2'b00, 5000, 5000); cycle("R6"); end
    check("R6", int'(sagFlag[0]), 1);
    drive(2'b01, 5000, 0); cycle("R3");

    // R5: count 0 acts as 1
    sagCount = 8'd0;
    drive(2'b10, 0, 3); cycle("R5");
    check("R5", int'(sagFlag[1]), 1);
    drive(2'b10, 0, 3000); cycle("R5");

    // R7: AND of both selected phases
    sagCount = 8'd2; sagMask = 2'b11;
    drive(2'b01, 1, 0); cycle("R7");
    drive(2'b01, 1, 0); cycle("R7");
    check("R7", int'(sagFlag[0]), 1);
    check("R7", int'(sagIrq), 0);
    drive(2'b10, 0, -2); cycle("R7");
    drive(2'b10, 0, -2); cycle("R7");
    check("R7", int'(sagIrq), 1);
    // R9: enable gates the pin
    sagIrqEn = 0; #1;
    check("R9", int'(sagIrq), 0);
    // R8: no mask
    sagIrqEn = 1; sagMask = 2'b00;
    drive(2'b11, 7, 7); cycle("R8");
    check("R8", int'(sagIrq), 0);
    check("R8", int'(sagFlag), 3);
    // R10: reset mid-sag
    doReset();
    check("R10", int'(sagFlag), 0);

    // Random traffic against the model
    for (int i = 0; i < 6000; i++) begin
      if (i % 40 == 0) begin
        sagThreshold = SAMPLE_W'(300 + $urandom_range(0, 1200));
        sagCount     = CNT_W'($urandom_range(0, 6));
        sagMask      = PHASES'($urandom_range(0, 3));
        sagIrqEn     = ($urandom_range(0, 3) != 0);
      end
      rst = ($urandom_range(0, 199) == 0);
      for (int p = 0; p < PHASES; p++) begin
        sampleValid[p] = ($urandom_range(0, 3) != 0);
        sd[p] = SAMPLE_W'(int'($urandom_range(0, 3000)) - 1500);
      end
      cycle(rst ? "R10" : "R6");
    end
    rst = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule